// File: doc/BRIEF.md
# Serial Port Queue Control and Receive Threshold

This block holds the write-only queue control byte of a 16550-style serial port and the few signals that depend on it. A host write strobe with a data byte sets the queue-mode enable and the receive threshold selection. The same write can request that the receive queue, the transmit queue, or both be emptied. The block turns each such request into a one-cycle clear pulse for the queue storage, which sits outside this block.

The receive queue reports its occupancy, from 0 to 16 entries. The block compares it against the selected threshold and drives a trigger flag to the interrupt logic. The transmit clear pulse goes only to the transmit queue storage and its counter. The transmit shift register is not connected to this block, so a character already being shifted out still completes.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset, `fifo_en` is 0, `rx_level` is 1, and `rx_clear`, `tx_clear` and `rx_trig` are 0.
- R2: A write with data bit 2 set produces a high `tx_clear` in the cycle that follows the clock edge sampling the write. That pulse lasts exactly one cycle.
- R3: A write with data bit 1 set produces a one-cycle `rx_clear` pulse with the same timing as R2.
- R4: Data bits 7:6 of a write select `rx_level`. The code 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. The selection holds until the next write.
- R5: Data bit 0 of a write becomes `fifo_en`. When a write changes the value of `fifo_en`, both `rx_clear` and `tx_clear` pulse, with the timing of R2.
- R6: `rx_trig` is high exactly when `fifo_en` is 1 and `rx_count` is greater than or equal to `rx_level`. It follows `rx_count` in the same cycle.
- R7: Data bits 5:3 of a write have no effect on any output.
- R8: Clear requests are not stored. With `wr_en` low, no clear pulse appears and `fifo_en` and `rx_level` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte being written |
| rx_count | input | 5 | Receive queue occupancy, 0 to 16 |
| fifo_en | output | 1 | Queue mode enabled |
| rx_clear | output | 1 | One-cycle clear pulse for the receive queue |
| tx_clear | output | 1 | One-cycle clear pulse for the transmit queue storage and counter |
| rx_level | output | 5 | Selected receive threshold |
| rx_trig | output | 1 | Receive occupancy has reached the threshold |

## Verification
The bench compares every output on every clock against a behavioural model. The stimulus targets the following corner cases:

- **Occupancy at the threshold edges.** The bench sweeps `rx_count` across the values just below, at and just above each threshold. An off-by-one comparison shows up as a trigger that fires one entry early or one entry late.
- **Writes that keep the mode.** Some writes rewrite the same value of bit 0. A design that compared against the wrong value would produce spurious clear pulses on these writes.
- **Back-to-back clear writes.** Consecutive writes that request a clear, and idle cycles after them, expose clear bits that stick high or pulses that last two cycles.
- **Writes that differ only in bits 5:3.** Pairs of such writes catch a threshold decoder that reads the wrong bits.

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl #(
  parameter int DEPTH = 16,
  parameter int LVL0  = 1,
  parameter int LVL1  = 4,
  parameter int LVL2  = 8,
  parameter int LVL3  = 14,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic [CW-1:0] rx_count,
  output logic          fifo_en,
  output logic          rx_clear,
  output logic          tx_clear,
  output logic [CW-1:0] rx_level,
  output logic          rx_trig
);

  logic [1:0] sel_q;
  logic       mode_flip;
  logic       unused_bits;

  assign unused_bits = ^wr_data[5:3];
  assign mode_flip   = wr_en && (wr_data[0] != fifo_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en  <= 1'b0;
      sel_q    <= 2'b00;
      rx_clear <= 1'b0;
      tx_clear <= 1'b0;
    end else begin
      rx_clear <= (wr_en && wr_data[1]) || mode_flip;
      tx_clear <= (wr_en && wr_data[2]) || mode_flip;
      if (wr_en) begin
        fifo_en <= wr_data[0];
        sel_q   <= wr_data[7:6];
      end
    end
  end

  always_comb begin
    case (sel_q)
      2'b00:   rx_level = CW'(LVL0);
      2'b01:   rx_level = CW'(LVL1);
      2'b10:   rx_level = CW'(LVL2);
      default: rx_level = CW'(LVL3);
    endcase
  end

  assign rx_trig = fifo_en && (rx_count >= rx_level);

  AST_TXCLR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clear |-> $past(wr_en)); // R2
  AST_RXCLR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clear |-> $past(wr_en)); // R3
  AST_LEVEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level == CW'(LVL0) || rx_level == CW'(LVL1) ||
    rx_level == CW'(LVL2) || rx_level == CW'(LVL3)); // R4
  AST_MODE_FLIP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en != $past(fifo_en)) |-> (rx_clear && tx_clear)); // R5
  AST_TRIG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> !rx_trig); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> ($stable(fifo_en) && $stable(rx_level) && !rx_clear && !tx_clear)); // R8

endmodule

// File: tb/uart_fifo_ctl_tb.sv
module uart_fifo_ctl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [4:0] rx_count = 5'd0;
  logic       fifo_en, rx_clear, tx_clear, rx_trig;
  logic [4:0] rx_level;

  int checks = 0;
  int fails  = 0;
  int m_en = 0, m_lvl = 1, m_rc = 0, m_tc = 0;
  bit done = 1'b0;

  uart_fifo_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rx_count(rx_count), .fifo_en(fifo_en), .rx_clear(rx_clear),
    .tx_clear(tx_clear), .rx_level(rx_level), .rx_trig(rx_trig)
  );

  always #2 clk = ~clk;

  function automatic int lvl_of(input int code);
    case (code)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_lvl = 1; m_rc = 0; m_tc = 0;
    end else begin
      automatic bit flip = wr_en && (int'(wr_data[0]) != m_en);
      m_rc = (wr_en && wr_data[1]) || flip;
      m_tc = (wr_en && wr_data[2]) || flip;
      if (wr_en) begin
        m_en  = wr_data[0];
        m_lvl = lvl_of(int'(wr_data[7:6]));
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk("R5 fifo_en", fifo_en, m_en);
    chk("R4 rx_level", rx_level, m_lvl);
    chk("R3 rx_clear", rx_clear, m_rc);
    chk("R2 tx_clear", tx_clear, m_tc);
    chk("R6 rx_trig", rx_trig, (m_en != 0 && int'(rx_count) >= m_lvl) ? 1 : 0);
  end

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = $urandom;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 fifo_en", fifo_en, 0);
    chk("R1 rx_level", rx_level, 1);
    chk("R1 clears", {rx_clear, tx_clear}, 0);
    chk("R1 rx_trig", rx_trig, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: transmit clear only, mode unchanged
    wr(8'h04);
    chk("R2 tx pulse", tx_clear, 1);
    chk("R2 no rx", rx_clear, 0);
    @(negedge clk);
    chk("R2 one cycle", tx_clear, 0);
    // R5: enabling the queues clears both
    wr(8'h01);
    chk("R5 both", {rx_clear, tx_clear}, 3);
    // R3: receive clear with mode kept
    wr(8'h03);
    chk("R3 rx pulse", rx_clear, 1);
    chk("R3 no tx", tx_clear, 0);
    // R8: idle cycles keep no clear
    repeat (3) begin
      @(negedge clk);
      chk("R8 no pulse", {rx_clear, tx_clear}, 0);
    end
    // R7: bits 5:3 ignored
    wr(8'h41);
    chk("R7 base lvl", rx_level, 4);
    wr(8'h79);
    chk("R7 lvl", rx_level, 4);
    chk("R7 en", fifo_en, 1);
    chk("R7 clears", {rx_clear, tx_clear}, 0);
    // R4/R6: threshold sweep in both modes
    for (int en = 0; en < 2; en++) begin
      for (int s = 0; s < 4; s++) begin
        wr(8'((s << 6) | en));
        for (int c = 0; c <= 16; c++) begin
          rx_count = 5'(c);
          @(negedge clk);
        end
      end
    end
    // back-to-back and random traffic
    wr(8'h06); wr(8'h06); wr(8'h00); wr(8'h01);
    for (int i = 0; i < 3000; i++) begin
      wr_en = ($urandom % 3) == 0;
      wr_data = $urandom;
      rx_count = 5'($urandom % 17);
      @(negedge clk);
    end
    wr_en = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule